// File: doc/BRIEF.md
# Failure Rate Window Checker

This block judges measured bit-failure counts against an acceptance window that depends on the assist condition under which the count was taken. It keeps a programmable table of upper and lower failure-count limits, one pair for each assist level (eight levels) of each of two assist types, so sixteen pairs in all. A separate result table keeps the most recent measured count for each of the same sixteen conditions.

When a measurement strobe arrives with an assist type, a 3-bit assist level and a count, the block looks up the limit pair for that condition and compares the count against both limits in parallel. It registers a verdict of pass, overshoot or undershoot, and it records the count in the result table. The entry index is `{type, level}` (type is the upper bit). Limits are loaded through a simple write port. Stored results can be read back combinationally by condition.

Top module: `fail_window_checker`

## Requirements
- R1: After reset, `res_seen`, `res_pass`, `res_over` and `res_under` are 0, and every result entry reads back count 0 with valid 0.
- R2: After reset, every upper limit is 16'hFFFF and every lower limit is 0, so any count passes until limits are programmed.
- R3: When `lim_we` is 1 on a clock edge, `lim_data` is written to the entry `{lim_type, lim_lvl}`. It goes into the upper limit when `lim_is_max` is 1 and into the lower limit when `lim_is_max` is 0.
- R4: A count passes (`res_pass`=1, `res_over`=0, `res_under`=0) exactly when lower limit <= count <= upper limit, compared as unsigned values; a count equal to either limit passes.
- R5: `res_over` is 1 when the count is above the upper limit and `res_under` is 1 when it is below the lower limit. The two flags are independent, so an inverted window (lower > upper) can raise both at once.
- R6: The comparison uses only the limit pair at entry `{meas_type, meas_lvl}`; limits stored at any other entry have no effect on the verdict.
- R7: The verdict is registered. It changes only on a clock edge where `meas_valid` is 1, is visible from the following cycle, and is held unchanged while `meas_valid` is 0. `res_seen` becomes 1 with the first measurement and stays 1.
- R8: On a measurement the count is stored in result entry `{meas_type, meas_lvl}` and that entry's valid bit is set; every other entry keeps its count and valid bit.
- R9: `rd_count` and `rd_valid` show, in the same cycle, the result entry addressed by `{rd_type, rd_lvl}`.
- R10: When a limit write and a measurement hit the same entry on the same edge, the verdict uses the limit value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_we | input | 1 | Limit write enable |
| lim_type | input | 1 | Assist type of the limit entry being written |
| lim_lvl | input | 3 | Assist level of the limit entry being written |
| lim_is_max | input | 1 | 1 writes the upper limit, 0 the lower limit |
| lim_data | input | 16 | Limit value |
| meas_valid | input | 1 | Measurement strobe |
| meas_type | input | 1 | Assist type of the measurement |
| meas_lvl | input | 3 | Assist level of the measurement |
| meas_count | input | 16 | Measured bit-failure count |
| rd_type | input | 1 | Readback assist type |
| rd_lvl | input | 3 | Readback assist level |
| rd_count | output | 16 | Stored count of the addressed entry |
| rd_valid | output | 1 | Addressed entry has been written since reset |
| res_seen | output | 1 | At least one verdict has been produced |
| res_pass | output | 1 | Last count lay inside its window |
| res_over | output | 1 | Last count was above its upper limit |
| res_under | output | 1 | Last count was below its lower limit |

## Verification
The situations that are hardest to reach from the ports are two. The first is a limit write landing on the same entry, on the same edge, as a measurement. The second is an inverted window in which both flags rise together. Random traffic almost never produces either, so the bench places both as directed cases. Counts exactly on a limit are also rare under random values. For that reason the random phase chooses each count within two of one of the entry's current limits, so that equality and off-by-one comparisons occur many times, with limits reprogrammed between measurements.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    typedef enum logic {
        LIM_LOW  = 1'b0,
        LIM_HIGH = 1'b1
    } lim_sel_e;

    typedef struct packed {
        logic pass;
        logic over;
        logic under;
    } verdict_t;

endpackage

// File: rtl/fwc_limit_table.sv
module fwc_limit_table
    import fwc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  lim_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_high,
    output logic [CNT_W-1:0] rd_low
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][CNT_W-1:0] high;
        logic [ENTRIES-1:0][CNT_W-1:0] low;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
                if (wr_sel == LIM_HIGH) tbl_d.high[e] = wr_data;
                else                    tbl_d.low[e]  = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_q.high[e] <= '1;
                tbl_q.low[e]  <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_high = tbl_q.high[rd_idx];
    assign rd_low  = tbl_q.low[rd_idx];

    // R3: a write lands in the selected half of the addressed entry
    a_r3_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == LIM_HIGH) |=> tbl_q.high[$past(wr_idx)] == $past(wr_data));
    a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == LIM_LOW) |=> tbl_q.low[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/fwc_result_table.sv
module fwc_result_table #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count,
    output logic             rd_valid
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][CNT_W-1:0] cnt;
        logic [ENTRIES-1:0]            vld;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
                res_d.cnt[e] = wr_data;
                res_d.vld[e] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rd_count = res_q.cnt[rd_idx];
    assign rd_valid = res_q.vld[rd_idx];

    // R8: a stored measurement is kept with its valid bit set
    a_r8_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (res_q.cnt[$past(wr_idx)] == $past(wr_data)) && res_q.vld[$past(wr_idx)]);
    // R8: valid bits never clear outside reset
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((res_q.vld & $past(res_q.vld)) == $past(res_q.vld)));

endmodule

// File: rtl/fwc_window_cmp.sv
module fwc_window_cmp
    import fwc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] lim_high,
    input  logic [CNT_W-1:0] lim_low,
    output verdict_t         verdict
);
    logic above, below;

    assign above = count > lim_high;
    assign below = count < lim_low;

    always_comb begin
        verdict.over  = above;
        verdict.under = below;
        verdict.pass  = !(above || below);
    end

endmodule

// File: rtl/fail_window_checker.sv
module fail_window_checker
    import fwc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 3,
    parameter int TYPE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lim_we,
    input  logic [TYPE_W-1:0] lim_type,
    input  logic [LVL_W-1:0]  lim_lvl,
    input  logic              lim_is_max,
    input  logic [CNT_W-1:0]  lim_data,
    input  logic              meas_valid,
    input  logic [TYPE_W-1:0] meas_type,
    input  logic [LVL_W-1:0]  meas_lvl,
    input  logic [CNT_W-1:0]  meas_count,
    input  logic [TYPE_W-1:0] rd_type,
    input  logic [LVL_W-1:0]  rd_lvl,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rd_valid,
    output logic              res_seen,
    output logic              res_pass,
    output logic              res_over,
    output logic              res_under
);
    localparam int IDX_W = TYPE_W + LVL_W;

    typedef struct packed {
        verdict_t v;
        logic     seen;
    } stat_t;

    logic [IDX_W-1:0] lim_idx, meas_idx, rd_idx;
    logic [CNT_W-1:0] cur_high, cur_low;
    verdict_t         cmp_v;
    stat_t            st_d, st_q;

    assign lim_idx  = {lim_type, lim_lvl};
    assign meas_idx = {meas_type, meas_lvl};
    assign rd_idx   = {rd_type, rd_lvl};

    fwc_limit_table #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_limits (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lim_we),
        .wr_idx  (lim_idx),
        .wr_sel  (lim_sel_e'(lim_is_max)),
        .wr_data (lim_data),
        .rd_idx  (meas_idx),
        .rd_high (cur_high),
        .rd_low  (cur_low)
    );

    fwc_window_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count    (meas_count),
        .lim_high (cur_high),
        .lim_low  (cur_low),
        .verdict  (cmp_v)
    );

    fwc_result_table #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_results (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (meas_valid),
        .wr_idx   (meas_idx),
        .wr_data  (meas_count),
        .rd_idx   (rd_idx),
        .rd_count (rd_count),
        .rd_valid (rd_valid)
    );

    always_comb begin
        st_d = st_q;
        if (meas_valid) begin
            st_d.v    = cmp_v;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_seen  = st_q.seen;
    assign res_pass  = st_q.v.pass;
    assign res_over  = st_q.v.over;
    assign res_under = st_q.v.under;

    // R4: a count inside the selected window yields a pass
    a_r4_inside_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_count <= cur_high && meas_count >= cur_low)
        |=> (res_pass && !res_over && !res_under));
    // R5: overshoot flagged
    a_r5_over_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_count > cur_high) |=> (res_over && !res_pass));
    // R5: undershoot flagged
    a_r5_under_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_count < cur_low) |=> (res_under && !res_pass));
    // R7: verdict held between strobes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |=> $stable({res_seen, res_pass, res_over, res_under}));
    // R7: seen follows the first strobe
    a_r7_seen: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> res_seen);

endmodule

// File: tb/fail_window_checker_test.sv
module fail_window_checker_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lim_we, lim_is_max, meas_valid;
    logic [0:0]  lim_type, meas_type, rd_type;
    logic [2:0]  lim_lvl, meas_lvl, rd_lvl;
    logic [15:0] lim_data, meas_count, rd_count;
    logic        rd_valid, res_seen, res_pass, res_over, res_under;

    always #4 clk = ~clk;

    fail_window_checker uut (
        .clk(clk), .rst_n(rst_n),
        .lim_we(lim_we), .lim_type(lim_type), .lim_lvl(lim_lvl),
        .lim_is_max(lim_is_max), .lim_data(lim_data),
        .meas_valid(meas_valid), .meas_type(meas_type), .meas_lvl(meas_lvl),
        .meas_count(meas_count),
        .rd_type(rd_type), .rd_lvl(rd_lvl), .rd_count(rd_count), .rd_valid(rd_valid),
        .res_seen(res_seen), .res_pass(res_pass), .res_over(res_over), .res_under(res_under)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_high[16];
    int m_low[16];
    int m_cnt[16];
    int m_vld[16];
    int e_seen, e_pass, e_over, e_under;

    function automatic int ex_over(int c, int hi);
        return (c > hi) ? 1 : 0;
    endfunction

    function automatic int ex_under(int c, int lo);
        return (c < lo) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(string req);
        chk(req, "res_seen",  int'(res_seen),  e_seen);
        chk(req, "res_pass",  int'(res_pass),  e_pass);
        chk(req, "res_over",  int'(res_over),  e_over);
        chk(req, "res_under", int'(res_under), e_under);
    endtask

    task automatic check_entry(string req, int t, int l);
        rd_type = 1'(t);
        rd_lvl  = 3'(l);
        #1;
        chk(req, "rd_count", int'(rd_count), m_cnt[t*8+l]);
        chk(req, "rd_valid", int'(rd_valid), m_vld[t*8+l]);
    endtask

    // One cycle: optional limit write and optional measurement, on the same edge
    task automatic step(bit lw, int lt, int ll, bit lhi, int ld,
                        bit mv, int mt, int ml, int mc);
        int li = lt*8 + ll;
        int mi = mt*8 + ml;
        int n_over, n_under;
        lim_we = lw; lim_type = 1'(lt); lim_lvl = 3'(ll);
        lim_is_max = lhi; lim_data = 16'(ld);
        meas_valid = mv; meas_type = 1'(mt); meas_lvl = 3'(ml); meas_count = 16'(mc);
        n_over  = ex_over(mc, m_high[mi]);   // R10: limits before this edge
        n_under = ex_under(mc, m_low[mi]);
        #1;
        check_flags("R7");                  // R7: nothing visible before the edge
        @(posedge clk);
        #2;
        if (lw) begin
            if (lhi) m_high[li] = ld;
            else     m_low[li]  = ld;
        end
        if (mv) begin
            m_cnt[mi] = mc;
            m_vld[mi] = 1;
            e_seen  = 1;
            e_over  = n_over;
            e_under = n_under;
            e_pass  = (n_over == 0 && n_under == 0) ? 1 : 0;
        end
        lim_we = 1'b0;
        meas_valid = 1'b0;
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        lim_we = 0; lim_type = 0; lim_lvl = 0; lim_is_max = 0; lim_data = 0;
        meas_valid = 0; meas_type = 0; meas_lvl = 0; meas_count = 0;
        rd_type = 0; rd_lvl = 0;
        for (int i = 0; i < 16; i++) begin
            m_high[i] = 16'hFFFF; m_low[i] = 0; m_cnt[i] = 0; m_vld[i] = 0;
        end
        e_seen = 0; e_pass = 0; e_over = 0; e_under = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check_flags("R1");
        for (int i = 0; i < 16; i++) check_entry("R1", i / 8, i % 8);
        rst_n = 1'b1;

        // R2: default limits accept extremes
        step(0, 0, 0, 0, 0, 1, 0, 0, 16'hFFFF);
        check_flags("R2");
        step(0, 0, 0, 0, 0, 1, 1, 7, 0);
        check_flags("R2");

        // R3, R4, R5: program a window and probe its edges
        step(1, 0, 3, 1, 100, 0, 0, 0, 0);
        step(1, 0, 3, 0, 50,  0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 3, 50);  check_flags("R4");
        step(0, 0, 0, 0, 0, 1, 0, 3, 100); check_flags("R4");
        step(0, 0, 0, 0, 0, 1, 0, 3, 101); check_flags("R5");
        step(0, 0, 0, 0, 0, 1, 0, 3, 49);  check_flags("R5");
        step(0, 0, 0, 0, 0, 1, 0, 3, 75);  check_flags("R3");

        // R5: inverted window raises both flags
        step(1, 1, 2, 0, 20, 0, 0, 0, 0);
        step(1, 1, 2, 1, 10, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1, 2, 15);
        check_flags("R5");
        chk("R5", "both flags", int'(res_over & res_under), 1);

        // R6: limits of another entry do not affect the verdict
        step(1, 1, 3, 1, 5, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 3, 80);
        check_flags("R6");
        chk("R6", "res_pass", int'(res_pass), 1);

        // R7: verdict held over idle cycles
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 0);
            check_flags("R7");
        end

        // R10: same-edge write and measure uses the old limit
        step(1, 0, 5, 1, 10, 1, 0, 5, 50);
        check_flags("R10");
        chk("R10", "res_pass", int'(res_pass), 1);
        step(0, 0, 0, 0, 0, 1, 0, 5, 50);
        check_flags("R10");

        // R8, R9: stored entries and an untouched one
        check_entry("R8", 0, 3);
        check_entry("R8", 1, 2);
        check_entry("R9", 0, 6);

        // Random phase, counts near current limits
        for (int it = 0; it < 600; it++) begin
            int t  = int'($urandom % 2);
            int l  = int'($urandom % 8);
            int mt = int'($urandom % 2);
            int ml = int'($urandom % 8);
            int mi = mt*8 + ml;
            int base = ($urandom % 2 == 1) ? m_high[mi] : m_low[mi];
            int mc = base + int'($urandom % 5) - 2;
            bit lw = ($urandom % 2) == 1;
            bit mv = ($urandom % 10) < 7;
            bit hi = ($urandom % 2) == 1;
            int ld = int'($urandom % 400);
            if (mc < 0) mc = 0;
            if (mc > 65535) mc = 65535;
            step(lw, t, l, hi, ld, mv, mt, ml, mc);
            if (mv) check_flags("R4");
            if (it % 8 == 0) check_entry("R9", int'($urandom % 2), int'($urandom % 8));
        end

        for (int i = 0; i < 16; i++) check_entry("R8", i / 8, i % 8);

        done = 1;
        report();
        $finish;
    end

endmodule